// File: doc/BRIEF.md
# Line-Delay FIFO for Sliding-Window Pixel Rows

This block is a single-clock first-in first-out store for one image line of pixels. It lets a sliding-window generator see the row above the current one. Writes and reads have separate enables. Every accepted write moves the write pointer on by one slot, and every accepted read moves the read pointer on by one slot. The block reports full and empty flags and a live occupancy level. A build parameter picks the read timing. In registered-output timing, a popped word appears on the output in the cycle after the accepted read. In first-word-fall-through timing, the oldest word already sits on the output before any read is requested.

A second build option turns the block into an exact one-line delay. In this line-gated mode a read is accepted only while the level equals the line width. If every valid pixel is written and a read is requested with each write, the level climbs to the line width and then stays there. Each word then leaves exactly one line after it entered. Two copies can be chained to give one-line and two-line delayed rows: the output of the first feeds the input of the second, and the second is written only while the first holds a full line.

In first-word-fall-through timing, the visible word is held by a two-state head register. In state `HEAD_VOID` nothing is shown. The *fill* transition moves it to `HEAD_SHOW`. That word comes straight from the write port when storage is empty, and from storage otherwise. The *drain-without-fill* transition returns it to `HEAD_VOID`. A drain that coincides with a fill stays in `HEAD_SHOW` and shows the next word.

Top module: `line_fifo`

## Requirements
- R1: A synchronous active-high `rst` clears the store: afterwards `level` is 0, `empty` is 1, `full` is 0 and, in registered-output timing, `rd_data` is 0.
- R2: Words leave in exactly the order they were accepted. No word is skipped or repeated. This also holds in line-gated mode.
- R3: In registered-output timing (`FWFT`=0), an accepted read puts the oldest word on `rd_data` in the following cycle. Without an accepted read, `rd_data` holds its value.
- R4: In first-word-fall-through timing (`FWFT`=1), `rd_data` shows the oldest stored word whenever `empty` is 0. After an accepted read it shows the next word from the following cycle on.
- R5: In first-word-fall-through timing, a word written into an empty store is on `rd_data` one cycle after the write edge. `empty` falls in that same cycle.
- R6: `full` is 1 exactly when `level` equals `DEPTH`, and `empty` is 1 exactly when `level` is 0. `level` never exceeds `DEPTH`.
- R7: A write while `full` is 1 is ignored: it neither raises `level` nor enters the data stream.
- R8: A read while `empty` is 1 is ignored: `level` stays 0 and no word is produced.
- R9: Without line gating, a write and a read in the same cycle on a store that is neither empty nor full leave `level` unchanged.
- R10: With line gating (`LINE_GATE`=1), a read is accepted only when `level` equals `LINE_W`. A write plus read at that level keeps `level` at `LINE_W`.
- R11: `level` changes by at most one per cycle. It rises by one for an accepted write alone, falls by one for an accepted read alone, and otherwise holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high clear |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Pixel to store |
| rd_en | input | 1 | Read (pop) request |
| rd_data | output | DATA_W | Popped word (registered timing) or oldest word (fall-through timing) |
| full | output | 1 | Level equals DEPTH |
| empty | output | 1 | Level is zero |
| level | output | $clog2(DEPTH)+1 | Number of words held |

## Verification
The hardest case to provoke is the fall-through head being refilled in the same cycle that it is drained. This comes in two forms: refill straight from the write port when storage is empty, and refill from storage otherwise. A closely related case is the line-gated store sitting at exactly the line width while reads are requested at other levels. To reach these cases, the bench uses a small configuration (depth 8, line width 5). It drives four instances, covering both timings with and without gating, with the same enable stream. That stream runs through write-heavy, read-heavy, balanced and always-both phases, with a reset in the middle of the run. The store therefore passes through empty, full and the gating level many times, and a bench model holding the stored words is compared against every output in every cycle.

// File: rtl/line_fifo_pkg.sv
package line_fifo_pkg;

    typedef enum logic {
        HEAD_VOID = 1'b0,
        HEAD_SHOW = 1'b1
    } head_state_t;

endpackage

// File: rtl/line_fifo_mem.sv
module line_fifo_mem #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 1024
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [DATA_W-1:0]        rdata
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/line_fifo_ctr.sv
module line_fifo_ctr #(
    parameter int DEPTH = 1024
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     put,
    input  logic                     take,
    output logic [$clog2(DEPTH)-1:0] waddr,
    output logic [$clog2(DEPTH)-1:0] raddr,
    output logic [$clog2(DEPTH):0]   stored
);
    localparam int AW = $clog2(DEPTH);

    always_ff @(posedge clk) begin
        if (rst) begin
            waddr  <= '0;
            raddr  <= '0;
            stored <= '0;
        end else begin
            if (put) begin
                waddr <= waddr + AW'(1);
            end
            if (take) begin
                raddr <= raddr + AW'(1);
            end
            unique case ({put, take})
                2'b10:   stored <= stored + 1'b1;
                2'b01:   stored <= stored - 1'b1;
                default: stored <= stored;
            endcase
        end
    end

endmodule

// File: rtl/line_fifo_head.sv
module line_fifo_head
    import line_fifo_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              drain,
    output logic              shown,
    output logic [DATA_W-1:0] head_data
);
    head_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HEAD_VOID;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HEAD_VOID: state_d = fill ? HEAD_SHOW : HEAD_VOID;
            HEAD_SHOW: state_d = (drain && !fill) ? HEAD_VOID : HEAD_SHOW;
            default:   state_d = HEAD_VOID;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_data <= '0;
        end else if (fill) begin
            head_data <= fill_data;
        end
    end

    assign shown = (state_q == HEAD_SHOW);

endmodule

// File: rtl/line_fifo.sv
module line_fifo #(
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 1024,
    parameter int LINE_W    = 640,
    parameter bit FWFT      = 1'b1,
    parameter bit LINE_GATE = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     rd_en,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     full,
    output logic                     empty,
    output logic [$clog2(DEPTH):0]   level
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic          accept_wr;
    logic          accept_rd;
    logic          rd_allowed;
    logic          put_ram;
    logic          take_ram;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [CW-1:0] stored;
    logic [DATA_W-1:0] mem_q;

    assign full       = (level == CW'(DEPTH));
    assign empty      = (level == '0);
    assign accept_wr  = wr_en && !full;
    assign rd_allowed = LINE_GATE ? (level == CW'(LINE_W)) : !empty;
    assign accept_rd  = rd_en && rd_allowed;

    line_fifo_mem #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_mem (
        .clk   (clk),
        .we    (put_ram),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (mem_q)
    );

    line_fifo_ctr #(
        .DEPTH (DEPTH)
    ) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .put    (put_ram),
        .take   (take_ram),
        .waddr  (waddr),
        .raddr  (raddr),
        .stored (stored)
    );

    generate
        if (FWFT) begin : g_fall_through
            logic              shown;
            logic              head_free;
            logic              from_ram;
            logic              bypass;
            logic              fill;
            logic [DATA_W-1:0] fill_data;

            assign head_free = !shown || accept_rd;
            assign from_ram  = (stored != '0) && head_free;
            assign bypass    = accept_wr && (stored == '0) && head_free;
            assign fill      = from_ram || bypass;
            assign fill_data = bypass ? wr_data : mem_q;
            assign put_ram   = accept_wr && !bypass;
            assign take_ram  = from_ram;
            assign level     = stored + CW'(shown);

            line_fifo_head #(
                .DATA_W (DATA_W)
            ) u_head (
                .clk       (clk),
                .rst       (rst),
                .fill      (fill),
                .fill_data (fill_data),
                .drain     (accept_rd),
                .shown     (shown),
                .head_data (rd_data)
            );
        end else begin : g_registered
            logic [DATA_W-1:0] out_q;

            assign put_ram  = accept_wr;
            assign take_ram = accept_rd;
            assign level    = stored;

            always_ff @(posedge clk) begin
                if (rst) begin
                    out_q <= '0;
                end else if (accept_rd) begin
                    out_q <= mem_q;
                end
            end

            assign rd_data = out_q;
        end
    endgenerate

endmodule

// File: rtl/line_fifo_checker.sv
module line_fifo_checker #(
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 1024,
    parameter int LINE_W    = 640,
    parameter bit FWFT      = 1'b1,
    parameter bit LINE_GATE = 1'b0
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   wr_en,
    input logic                   rd_en,
    input logic [DATA_W-1:0]      rd_data,
    input logic                   full,
    input logic                   empty,
    input logic [$clog2(DEPTH):0] level
);
    localparam int CW = $clog2(DEPTH) + 1;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        level <= CW'(DEPTH)); // R6

    AST_FLAGS_APART: assert property (@(posedge clk) disable iff (rst)
        !(full && empty)); // R6

    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en) |=> (full && $stable(level))); // R7

    AST_EMPTY_READ_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en && !wr_en) |=> empty); // R8

    AST_BOTH_KEEP_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (!LINE_GATE && !empty && !full && wr_en && rd_en) |=> $stable(level)); // R9

    AST_LINE_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (LINE_GATE && level == CW'(LINE_W) && wr_en && rd_en) |=> (level == CW'(LINE_W))); // R10

    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((level == $past(level)) || (level == $past(level) + 1'b1)
                  || (level + 1'b1 == $past(level)))); // R11

    AST_FALL_THROUGH_SHOW: assert property (@(posedge clk) disable iff (rst)
        (FWFT && empty && wr_en) |=> !empty); // R5

    AST_REGISTERED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!FWFT && !rd_en) |=> $stable(rd_data)); // R3

endmodule

bind line_fifo line_fifo_checker #(
    .DATA_W    (DATA_W),
    .DEPTH     (DEPTH),
    .LINE_W    (LINE_W),
    .FWFT      (FWFT),
    .LINE_GATE (LINE_GATE)
) u_line_fifo_checker (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .full    (full),
    .empty   (empty),
    .level   (level)
);

// File: tb/test_line_fifo.sv
`timescale 1ns/1ps
module test_line_fifo;
    localparam int DW = 8;
    localparam int DP = 8;
    localparam int LW = 5;
    localparam int CW = $clog2(DP) + 1;
    localparam int NI = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] dout  [NI];
    logic          fl    [NI];
    logic          em    [NI];
    logic [CW-1:0] lvl   [NI];

    // instance order: 0 fall-through, 1 registered, 2 gated fall-through, 3 gated registered
    bit is_ft [NI] = '{1'b1, 1'b0, 1'b1, 1'b0};
    bit gated [NI] = '{1'b0, 1'b0, 1'b1, 1'b1};

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    int  mbuf [NI][16];
    int  hd   [NI];
    int  sz   [NI];
    int  last [NI];
    string tag_l [NI];
    string tag_d [NI];

    always #2.5 clk = ~clk;

    line_fifo #(.DATA_W(DW), .DEPTH(DP), .LINE_W(LW), .FWFT(1'b1), .LINE_GATE(1'b0)) i_line_fifo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(dout[0]), .full(fl[0]), .empty(em[0]), .level(lvl[0]));
    line_fifo #(.DATA_W(DW), .DEPTH(DP), .LINE_W(LW), .FWFT(1'b0), .LINE_GATE(1'b0)) i_line_fifo_reg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(dout[1]), .full(fl[1]), .empty(em[1]), .level(lvl[1]));
    line_fifo #(.DATA_W(DW), .DEPTH(DP), .LINE_W(LW), .FWFT(1'b1), .LINE_GATE(1'b1)) i_line_fifo_gft (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(dout[2]), .full(fl[2]), .empty(em[2]), .level(lvl[2]));
    line_fifo #(.DATA_W(DW), .DEPTH(DP), .LINE_W(LW), .FWFT(1'b0), .LINE_GATE(1'b1)) i_line_fifo_greg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(dout[3]), .full(fl[3]), .empty(em[3]), .level(lvl[3]));

    task automatic chk(input string tag, input int i, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s inst%0d actual=%0d expected=%0d", tag, i, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < NI; i++) begin
            hd[i] = 0; sz[i] = 0; last[i] = 0;
            tag_l[i] = "R11"; tag_d[i] = "R2";
        end
    endtask

    // R1: reset state at the ports
    task automatic check_reset();
        for (int i = 0; i < NI; i++) begin
            chk("R1", i, int'(lvl[i]), 0);
            chk("R1", i, int'(em[i]), 1);
            chk("R1", i, int'(fl[i]), 0);
            if (!is_ft[i]) chk("R1", i, int'(dout[i]), 0);
        end
    endtask

    task automatic check_all();
        for (int i = 0; i < NI; i++) begin
            chk(tag_l[i], i, int'(lvl[i]), sz[i]);
            chk("R6", i, int'(fl[i]), int'(sz[i] == DP));
            chk("R6", i, int'(em[i]), int'(sz[i] == 0));
            if (is_ft[i]) begin
                if (sz[i] > 0) chk(tag_d[i], i, int'(dout[i]), mbuf[i][hd[i]]);
            end else begin
                chk(tag_d[i], i, int'(dout[i]), last[i]);
            end
        end
    endtask

    task automatic step(input int pw, input int pr);
        logic w, r;
        logic [DW-1:0] d;
        @(negedge clk);
        check_all();
        w = ($urandom_range(99) < pw);
        r = ($urandom_range(99) < pr);
        d = DW'($urandom);
        for (int i = 0; i < NI; i++) begin
            bit push, pop, was_empty;
            push = w && (sz[i] < DP);
            pop  = r && (gated[i] ? (sz[i] == LW) : (sz[i] > 0));
            was_empty = (sz[i] == 0);
            if (gated[i])                       tag_l[i] = "R10";
            else if (w && sz[i] == DP)           tag_l[i] = "R7";
            else if (r && sz[i] == 0)            tag_l[i] = "R8";
            else if (w && r)                     tag_l[i] = "R9";
            else                                 tag_l[i] = "R11";
            if (gated[i])                        tag_d[i] = "R2";
            else if (!is_ft[i])                  tag_d[i] = "R3";
            else if (was_empty && push)          tag_d[i] = "R5";
            else                                 tag_d[i] = "R4";
            if (pop) begin
                if (!is_ft[i]) last[i] = mbuf[i][hd[i]];
                hd[i] = (hd[i] + 1) % 16;
                sz[i]--;
            end
            if (push) begin
                mbuf[i][(hd[i] + sz[i]) % 16] = int'(d);
                sz[i]++;
            end
        end
        wr_en   = w;
        rd_en   = r;
        wr_data = d;
    endtask

    task automatic phase(input int n, input int pw, input int pr);
        for (int k = 0; k < n; k++) step(pw, pr);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset();
        rst = 1'b0;
        phase(600, 90, 20);
        phase(600, 20, 90);
        phase(800, 50, 50);
        phase(400, 100, 100);
        phase(600, 70, 60);
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        @(negedge clk);
        check_reset();
        model_clear();
        rst = 1'b0;
        phase(300, 100, 100);
        phase(500, 60, 45);
        phase(300, 10, 100);
        @(negedge clk);
        check_all();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule